// File: doc/BRIEF.md
# Exponential Backoff Retry Controller

This block sits next to a requester that performs atomic compare-and-swap attempts. Each time the requester reports a failed attempt, the controller asks a separate stall engine to hold the core for a number of cycles. The length of that stall grows exponentially with repeated failures of the same operation. A reported success returns the growth to its starting point.

The controller keeps a backoff value that starts at 1. When a failure is accepted, it offers one stall request whose cycle count is the current value shifted left by 7. This treats one backoff unit as roughly 128 cycles. The whole wait goes out as a single request, not as a series of fixed-size waits. In the same cycle the value is doubled, but only while it is not yet above the cap of 4096. Once the value passes the cap it stays fixed, so every later stall has the same length.

The stall request is a valid/ready channel. When the controller raises valid, it keeps valid high and holds the cycle count unchanged until the stall engine accepts with ready. Valid drops in the cycle after that handshake. The controller then waits for the engine's done pulse. Busy is high for the whole episode: from the cycle after an accepted failure until the cycle after done.

Top module: `backoff_retry_ctrl`

## Requirements
- R1: After reset, stall_valid_o, busy_o and stall_cycles_o are all 0, and the backoff value is 1, so the first failure requests 128 cycles.
- R2: A fail_i pulse while idle, with success_i low, makes stall_valid_o and busy_o high in the next cycle. In that cycle stall_cycles_o equals the backoff value shifted left by 7.
- R3: Each accepted failure doubles the backoff value (a shift left by one), so successive requests carry 128, 256, 512 and so on.
- R4: The value is doubled only while it is not greater than 4096. A value of 8192 is never doubled, so the requested count stops at 1048576 (bit 20 set) and repeats there.
- R5: While stall_valid_o is high and stall_ready_i is low, stall_valid_o stays high and stall_cycles_o does not change.
- R6: busy_o stays high until a stall_done_i pulse arrives after the handshake. It drops in the following cycle. A stall_done_i that arrives while the request is still on offer is ignored.
- R7: A fail_i pulse while busy_o is high starts no request and does not change the backoff value.
- R8: success_i resets the backoff value to 1 in any state. If success_i and fail_i are high in the same idle cycle, the failure is not accepted.
- R9: Each accepted failure produces exactly one handshake. stall_valid_o is low in the cycle after stall_valid_o and stall_ready_i are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fail_i | input | 1 | One-cycle pulse: the atomic attempt failed |
| success_i | input | 1 | One-cycle pulse: the atomic attempt succeeded |
| stall_valid_o | output | 1 | Stall request on offer |
| stall_ready_i | input | 1 | Stall engine accepts the offered request |
| stall_cycles_o | output | 21 | Requested stall length in cycles |
| stall_done_i | input | 1 | One-cycle pulse: the granted stall has finished |
| busy_o | output | 1 | A backoff episode is in progress |

## Verification
The backoff value is internal, so a fault in it shows up at the ports only when the next failure is accepted: the count offered one cycle later is wrong. The bench therefore follows every disturbance (an ignored fail, a success, a reset) with a fresh failure and reads the count that failure requests. A fault in the sequencer appears sooner. It shows as valid or busy at the wrong level one cycle after a handshake, a done pulse or a fail pulse, and the bench samples every such cycle.

// File: rtl/backoff_pkg.sv
package backoff_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_WAIT  = 2'd2
  } bo_state_e;

  // Bits needed to hold a value that may reach twice the cap
  function automatic int value_width(input int cap);
    return $clog2(cap) + 2;
  endfunction

endpackage

// File: rtl/backoff_value.sv
// Holds the exponential backoff value: restart to the initial setting,
// doubling on each accepted failure until the cap has been passed.
module backoff_value #(
  parameter int INIT_VAL = 1,
  parameter int LIMIT    = 4096,
  parameter int VAL_W    = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  output logic [VAL_W-1:0] value
);
  localparam logic [VAL_W-1:0] INIT_V  = VAL_W'(INIT_VAL);
  localparam logic [VAL_W-1:0] LIMIT_V = VAL_W'(LIMIT);

  logic [VAL_W-1:0] next_value;
  logic             may_grow;

  assign may_grow = (value <= LIMIT_V);

  always_comb begin
    next_value = value;
    if (restart)
      next_value = INIT_V;
    else if (advance && may_grow)
      next_value = {value[VAL_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) value <= INIT_V;
    else        value <= next_value;
  end
endmodule

// File: rtl/stall_scaler.sv
// Turns backoff units into a cycle count by a fixed left shift.
module stall_scaler #(
  parameter int VAL_W = 14,
  parameter int SHIFT = 7,
  localparam int CNT_W = VAL_W + SHIFT
) (
  input  logic [VAL_W-1:0] units,
  output logic [CNT_W-1:0] cycles
);
  genvar b;
  generate
    for (b = 0; b < CNT_W; b++) begin : g_bit
      if (b < SHIFT) begin : g_zero
        assign cycles[b] = 1'b0;
      end else begin : g_copy
        assign cycles[b] = units[b-SHIFT];
      end
    end
  endgenerate
endmodule

// File: rtl/stall_sequencer.sv
// Accepts a failure, offers one stall request on a valid/ready channel,
// then waits for the done pulse.
module stall_sequencer
  import backoff_pkg::*;
#(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fail_i,
  input  logic             success_i,
  input  logic             stall_ready_i,
  input  logic             stall_done_i,
  input  logic [CNT_W-1:0] cycles_in,
  output logic             accept_o,
  output logic             stall_valid_o,
  output logic [CNT_W-1:0] stall_cycles_o,
  output logic             busy_o
);
  bo_state_e state, state_nx;
  logic [CNT_W-1:0] cnt_q;

  assign accept_o = (state == ST_IDLE) && fail_i && !success_i;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (accept_o)      state_nx = ST_OFFER;
      ST_OFFER: if (stall_ready_i) state_nx = ST_WAIT;
      ST_WAIT:  if (stall_done_i)  state_nx = ST_IDLE;
      default:                     state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      state <= state_nx;
      if (accept_o) cnt_q <= cycles_in;
    end
  end

  assign stall_valid_o  = (state == ST_OFFER);
  assign stall_cycles_o = cnt_q;
  assign busy_o         = (state != ST_IDLE);
endmodule

// File: rtl/backoff_retry_ctrl.sv
module backoff_retry_ctrl #(
  parameter int INIT_VAL = 1,
  parameter int LIMIT    = 4096,
  parameter int SHIFT    = 7,
  localparam int VAL_W   = backoff_pkg::value_width(LIMIT),
  localparam int CNT_W   = VAL_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fail_i,
  input  logic             success_i,
  output logic             stall_valid_o,
  input  logic             stall_ready_i,
  output logic [CNT_W-1:0] stall_cycles_o,
  input  logic             stall_done_i,
  output logic             busy_o
);
  logic [VAL_W-1:0] value;
  logic [CNT_W-1:0] scaled;
  logic             accept;

  backoff_value #(.INIT_VAL(INIT_VAL), .LIMIT(LIMIT), .VAL_W(VAL_W)) u_value (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (success_i),
    .advance (accept),
    .value   (value)
  );

  stall_scaler #(.VAL_W(VAL_W), .SHIFT(SHIFT)) u_scale (
    .units  (value),
    .cycles (scaled)
  );

  stall_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .fail_i         (fail_i),
    .success_i      (success_i),
    .stall_ready_i  (stall_ready_i),
    .stall_done_i   (stall_done_i),
    .cycles_in      (scaled),
    .accept_o       (accept),
    .stall_valid_o  (stall_valid_o),
    .stall_cycles_o (stall_cycles_o),
    .busy_o         (busy_o)
  );
endmodule

// File: rtl/backoff_retry_ctrl_chk.sv
module backoff_retry_ctrl_chk #(
  parameter int SHIFT = 7,
  parameter int CNT_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fail_i,
  input logic             success_i,
  input logic             stall_valid_o,
  input logic             stall_ready_i,
  input logic [CNT_W-1:0] stall_cycles_o,
  input logic             stall_done_i,
  input logic             busy_o
);
  a_r2_fail_starts_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && fail_i && !success_i) |=> (stall_valid_o && busy_o));

  a_r5_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_valid_o && !stall_ready_i) |=> (stall_valid_o && $stable(stall_cycles_o)));

  a_r9_single_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_valid_o && stall_ready_i) |=> (!stall_valid_o && busy_o));

  a_r6_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    stall_valid_o |-> busy_o);

  a_r6_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !stall_valid_o && stall_done_i) |=> !busy_o);

  a_r7_busy_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (stall_valid_o || !stall_done_i)) |=> busy_o);

  a_r4_count_power_of_two: assert property (@(posedge clk) disable iff (!rst_n)
    stall_valid_o |-> (($countones(stall_cycles_o) == 1) && (stall_cycles_o[SHIFT-1:0] == '0)));

  a_r8_cosuccess_blocks_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && fail_i && success_i) |=> !busy_o);
endmodule

bind backoff_retry_ctrl backoff_retry_ctrl_chk #(.SHIFT(SHIFT), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fail_i         (fail_i),
  .success_i      (success_i),
  .stall_valid_o  (stall_valid_o),
  .stall_ready_i  (stall_ready_i),
  .stall_cycles_o (stall_cycles_o),
  .stall_done_i   (stall_done_i),
  .busy_o         (busy_o)
);

// File: tb/backoff_retry_ctrl_test.sv
module backoff_retry_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 21;
  localparam int NVEC = 16;

  // stimulus: ready delay, extra fail during wait, done delay; expected count
  localparam int RDY_DLY [NVEC] = '{0,1,2,0,1,2,0,1,2,0,1,2,0,1,2,0};
  localparam bit XFAIL   [NVEC] = '{0,1,0,1,0,1,0,1,0,1,0,1,0,1,0,1};
  localparam int DONE_DLY[NVEC] = '{0,1,2,3,0,1,2,3,0,1,2,3,0,1,2,3};
  localparam logic [CW-1:0] EXP_CNT[NVEC] = '{
    21'h000080, 21'h000100, 21'h000200, 21'h000400,
    21'h000800, 21'h001000, 21'h002000, 21'h004000,
    21'h008000, 21'h010000, 21'h020000, 21'h040000,
    21'h080000, 21'h100000, 21'h100000, 21'h100000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fail_i = 1'b0, success_i = 1'b0, stall_ready_i = 1'b0, stall_done_i = 1'b0;
  logic stall_valid_o, busy_o;
  logic [CW-1:0] stall_cycles_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  backoff_retry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .fail_i(fail_i), .success_i(success_i),
    .stall_valid_o(stall_valid_o), .stall_ready_i(stall_ready_i),
    .stall_cycles_o(stall_cycles_o), .stall_done_i(stall_done_i), .busy_o(busy_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  // one failure episode from idle back to idle
  task automatic run_fail(input int rdly, input bit xf, input int ddly,
                          input logic [CW-1:0] exp, input string tag);
    fail_i = 1'b1; tick; fail_i = 1'b0;
    check({"R2 valid ", tag}, 32'(stall_valid_o), 1);
    check({"R6 busy ", tag}, 32'(busy_o), 1);
    check({"R3/R4 count ", tag}, 32'(stall_cycles_o), 32'(exp));
    for (int k = 0; k < rdly; k++) begin
      tick;
      check({"R5 hold valid ", tag}, 32'(stall_valid_o), 1);
      check({"R5 hold count ", tag}, 32'(stall_cycles_o), 32'(exp));
    end
    stall_ready_i = 1'b1; tick; stall_ready_i = 1'b0;
    check({"R9 valid drops ", tag}, 32'(stall_valid_o), 0);
    check({"R6 busy in wait ", tag}, 32'(busy_o), 1);
    if (xf) begin
      fail_i = 1'b1; tick; fail_i = 1'b0;
      check({"R7 no new offer ", tag}, 32'(stall_valid_o), 0);
      check({"R7 still busy ", tag}, 32'(busy_o), 1);
    end
    for (int k = 0; k < ddly; k++) tick;
    stall_done_i = 1'b1; tick; stall_done_i = 1'b0;
    check({"R6 busy clears ", tag}, 32'(busy_o), 0);
    check({"R9 no repeat ", tag}, 32'(stall_valid_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick; tick;
    // R1 reset state
    check("R1 valid at reset", 32'(stall_valid_o), 0);
    check("R1 busy at reset", 32'(busy_o), 0);
    check("R1 count at reset", 32'(stall_cycles_o), 0);
    rst_n = 1'b1; tick;

    // table walk: doubling then saturation at the cap (R3, R4)
    for (int i = 0; i < NVEC; i++)
      run_fail(RDY_DLY[i], XFAIL[i], DONE_DLY[i], EXP_CNT[i], $sformatf("vec%0d", i));

    // R8: success while idle restores the initial value
    success_i = 1'b1; tick; success_i = 1'b0;
    run_fail(0, 0, 0, 21'h000080, "R8 after success");

    // R8: success and fail together, fail not accepted, value back to 1
    fail_i = 1'b1; success_i = 1'b1; tick; fail_i = 1'b0; success_i = 1'b0;
    check("R8 cofail no offer", 32'(stall_valid_o), 0);
    check("R8 cofail not busy", 32'(busy_o), 0);
    tick;
    check("R8 cofail still idle", 32'(busy_o), 0);
    run_fail(0, 0, 0, 21'h000080, "R8 after cofail");
    run_fail(1, 0, 0, 21'h000100, "R3 second");

    // R8: success during a busy episode
    fail_i = 1'b1; tick; fail_i = 1'b0;
    check("R3 count 512", 32'(stall_cycles_o), 32'h200);
    stall_ready_i = 1'b1; tick; stall_ready_i = 1'b0;
    success_i = 1'b1; tick; success_i = 1'b0;
    check("R8 busy unaffected", 32'(busy_o), 1);
    stall_done_i = 1'b1; tick; stall_done_i = 1'b0;
    run_fail(0, 0, 0, 21'h000080, "R8 success in wait");

    // R6: done while still on offer is ignored
    fail_i = 1'b1; tick; fail_i = 1'b0;
    check("R3 count 256", 32'(stall_cycles_o), 32'h100);
    stall_done_i = 1'b1; tick; stall_done_i = 1'b0;
    check("R6 early done valid", 32'(stall_valid_o), 1);
    check("R6 early done busy", 32'(busy_o), 1);
    stall_ready_i = 1'b1; tick; stall_ready_i = 1'b0;
    check("R6 wait after early done", 32'(busy_o), 1);
    stall_done_i = 1'b1; tick; stall_done_i = 1'b0;
    check("R6 idle after done", 32'(busy_o), 0);

    // R1: reset in the middle of a run restores value 1
    run_fail(0, 0, 0, 21'h000200, "R3 third");
    fail_i = 1'b1; tick; fail_i = 1'b0;
    rst_n = 1'b0; tick;
    check("R1 mid reset valid", 32'(stall_valid_o), 0);
    check("R1 mid reset busy", 32'(busy_o), 0);
    check("R1 mid reset count", 32'(stall_cycles_o), 0);
    rst_n = 1'b1; tick;
    run_fail(2, 1, 1, 21'h000080, "R1 after reset");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule